// File: doc/BRIEF.md
# UART Register Interface

This block is the processor-side register file of a 16550-style serial port. A simple 16-bit bus (address, size, read and write strobes, write data) reaches ten 32-bit-aligned register slots. Each read returns its data one cycle after the strobe. Every access that is outside the map, or that is malformed, raises an error flag in that same response cycle. On the serial side, the block emits transmit bytes on a valid/ready stream and takes received bytes from a second valid/ready stream. It also drives two event lines that an interrupt or DMA controller can consume.

A divisor-access bit in the line-control register switches the two lowest slots between the data and interrupt-enable registers and the two divisor bytes. The line-status register merges bits latched since the last read with live line conditions, and a read clears the latched part. A loopback mode in the modem-control register turns the next transmitted byte into the next received byte.

Top module: `uart_regfile`

## Requirements
- R1: After reset, reads return: divisor low 0x0001, identification register (offset 0x08) 0x0001, line status (offset 0x14) 0x0060 when the live status is all zero, and 0 for the divisor high, interrupt enable (0x04), line control (0x0C), modem control (0x10), scratch (0x1C) and global control (0x24). tx_valid, rx_ready, tx_event, rx_event and bus_err are 0.
- R2: When line control bit 7 is 1, offsets 0x00 and 0x04 read and write the divisor low and high registers, and a write to 0x00 sends nothing. When bit 7 is 0, the same offsets reach the data register and the interrupt-enable register.
- R3: Writes to 0x08 and 0x14 change nothing. Line control, modem control, scratch and global control store all 16 written bits and read them back.
- R4: A line-status read returns the latched bits ORed with the live bits, then clears the latched bits. The live bits are: bit 0 data ready, bit 5 = tx_ready, bit 6 = tx_idle.
- R5: A data write with bit 7 of line control at 0 puts write data bits 7:0 on tx_data and raises tx_valid in the next cycle. tx_valid holds until a cycle in which tx_ready is 1.
- R6: tx_event is a one-cycle pulse, in the cycle after a data write, when interrupt-enable bit 1 is 1. It stays 0 otherwise.
- R7: With loopback off, a data read while rx_valid is 1 asserts rx_ready in the strobe cycle and returns rx_data. With no byte available, it returns the previously read byte.
- R8: When modem-control bit 4 is 1, a data write stores its byte (which is still sent on the transmit stream), and the next data read returns that byte. rx_ready stays 0 and rx_valid does not affect data ready.
- R9: rx_event equals interrupt-enable bit 0 ANDed with data ready. Data ready is a held loopback byte, or rx_valid while loopback is off.
- R10: These accesses raise bus_err in the response cycle and change no state: offsets 0x18 and 0x20, offsets above 0x24, addresses with bits 1:0 nonzero, bus_size other than 1 (16-bit), and both strobes at once. Such a read returns 0.
- R11: bus_rdata keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| bus_err | output | 1 | Invalid-access flag, one cycle after the strobe |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmit sink accepts the byte; also live empty status |
| tx_idle | input | 1 | Transmitter fully drained (live status) |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Received byte taken this cycle |
| tx_event | output | 1 | Transmit event pulse |
| rx_event | output | 1 | Receive event level |

## Verification
The bench builds the block with the default ADDR_W of 8. This makes every offset up to 0xFC reachable, so the bench can probe the two holes in the map, the first slots past its end and misaligned addresses. The narrow address also keeps each decode path short enough to exercise fully. A scoreboard checks reads against expected values across divisor aliasing, loopback and external receive.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int REG_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 10;

    localparam int LCR_DIV_BIT  = 7;
    localparam int MCR_LOOP_BIT = 4;
    localparam int IER_RX_BIT   = 0;
    localparam int IER_TX_BIT   = 1;
    localparam int LSR_DR_BIT   = 0;
    localparam int LSR_THRE_BIT = 5;
    localparam int LSR_TEMT_BIT = 6;

    localparam logic [1:0]       SIZE_HALF   = 2'd1;
    localparam logic [REG_W-1:0] DIVLO_RESET = 16'h0001;
    localparam logic [REG_W-1:0] IDENT_VALUE = 16'h0001;
    localparam logic [REG_W-1:0] LSR_RESET   = 16'h0060;

    typedef enum logic [3:0] {
        SEL_DATA, SEL_IER, SEL_IIR, SEL_LCR, SEL_MCR,
        SEL_LSR, SEL_SCR, SEL_GCTL, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     bad;
        reg_sel_e sel;
    } access_t;

    function automatic reg_sel_e slot_sel(input logic [3:0] slot);
        case (slot)
            4'd0:    return SEL_DATA;
            4'd1:    return SEL_IER;
            4'd2:    return SEL_IIR;
            4'd3:    return SEL_LCR;
            4'd4:    return SEL_MCR;
            4'd5:    return SEL_LSR;
            4'd7:    return SEL_SCR;
            4'd9:    return SEL_GCTL;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] live_status(input logic dr,
                                                     input logic thre,
                                                     input logic temt);
        logic [REG_W-1:0] v;
        v = '0;
        v[LSR_DR_BIT]   = dr;
        v[LSR_THRE_BIT] = thre;
        v[LSR_TEMT_BIT] = temt;
        return v;
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output access_t           acc
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot_idx;
    logic              in_map;
    reg_sel_e          sel;
    logic              ok;

    always_comb begin
        slot_idx = bus_addr[ADDR_W-1:2];
        in_map   = slot_idx < SLOT_W'(NUM_SLOTS);
        sel      = in_map ? slot_sel(slot_idx[3:0]) : SEL_NONE;
        ok       = (bus_addr[1:0] == 2'b00) && (sel != SEL_NONE)
                   && (bus_size == SIZE_HALF) && !(bus_rd && bus_wr);
        acc.rd   = bus_rd && ok;
        acc.wr   = bus_wr && ok;
        acc.bad  = (bus_rd || bus_wr) && !ok;
        acc.sel  = sel;
    end

    always_comb begin
        assert_one_kind_R10: assert (!(acc.bad && (acc.rd || acc.wr)));
    end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              dr_live
);
    logic [BYTE_W-1:0] rbr_q, loop_q;
    logic              loop_full_q;
    logic              take_loop, take_ext;

    always_comb begin
        take_loop = data_rd && loop_full_q;
        take_ext  = data_rd && !loop_full_q && !loop_en && rx_valid;
        rx_ready  = take_ext;
        rd_byte   = take_loop ? loop_q : (take_ext ? rx_data : rbr_q);
        dr_live   = loop_full_q || (!loop_en && rx_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr_q       <= '0;
            loop_q      <= '0;
            loop_full_q <= 1'b0;
        end else begin
            if (data_rd) rbr_q <= rd_byte;
            if (data_wr && loop_en) begin
                loop_q      <= wr_byte;
                loop_full_q <= 1'b1;
            end else if (take_loop) begin
                loop_full_q <= 1'b0;
            end
        end
    end

    assert_loop_blocks_rx_R8: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> !rx_ready);
    assert_ready_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> rx_valid);
    assert_loop_byte_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && loop_en) |=> dr_live);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lsr_rd,
    input  logic [REG_W-1:0] live,
    output logic [REG_W-1:0] rd_val
);
    logic [REG_W-1:0] sticky_q;

    assign rd_val = sticky_q | live;

    always_ff @(posedge clk) begin
        if (rst)         sticky_q <= LSR_RESET;
        else if (lsr_rd) sticky_q <= '0;
    end

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        lsr_rd |=> (rd_val == live));
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_idle,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              tx_event,
    output logic              rx_event
);
    access_t acc;
    logic [REG_W-1:0]  dll_q, dlh_q, ier_q, lcr_q, mcr_q, scr_q, gctl_q;
    logic [REG_W-1:0]  rdata_q, rd_mux, lsr_val;
    logic [BYTE_W-1:0] tx_q, rx_byte;
    logic              tx_valid_q, tx_event_q, err_q;
    logic              dlab, data_wr, data_rd, lsr_rd, dr_live;

    uart_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .acc(acc)
    );

    always_comb begin
        dlab    = lcr_q[LCR_DIV_BIT];
        data_wr = acc.wr && (acc.sel == SEL_DATA) && !dlab;
        data_rd = acc.rd && (acc.sel == SEL_DATA) && !dlab;
        lsr_rd  = acc.rd && (acc.sel == SEL_LSR);
    end

    uart_rx_path u_rx (
        .clk(clk), .rst(rst), .loop_en(mcr_q[MCR_LOOP_BIT]),
        .data_wr(data_wr), .wr_byte(bus_wdata[BYTE_W-1:0]),
        .data_rd(data_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rd_byte(rx_byte), .dr_live(dr_live)
    );

    uart_line_status u_lsr (
        .clk(clk), .rst(rst), .lsr_rd(lsr_rd),
        .live(live_status(dr_live, tx_ready, tx_idle)), .rd_val(lsr_val)
    );

    always_comb begin
        case (acc.sel)
            SEL_DATA: rd_mux = dlab ? dll_q : {{(REG_W-BYTE_W){1'b0}}, rx_byte};
            SEL_IER:  rd_mux = dlab ? dlh_q : ier_q;
            SEL_IIR:  rd_mux = IDENT_VALUE;
            SEL_LCR:  rd_mux = lcr_q;
            SEL_MCR:  rd_mux = mcr_q;
            SEL_LSR:  rd_mux = lsr_val;
            SEL_SCR:  rd_mux = scr_q;
            SEL_GCTL: rd_mux = gctl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dll_q <= DIVLO_RESET;
            {dlh_q, ier_q, lcr_q, mcr_q, scr_q, gctl_q} <= '0;
            rdata_q    <= '0;
            tx_q       <= '0;
            tx_valid_q <= 1'b0;
            tx_event_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            err_q      <= acc.bad;
            tx_event_q <= data_wr && ier_q[IER_TX_BIT];
            if (acc.rd)                rdata_q <= rd_mux;
            else if (acc.bad && bus_rd) rdata_q <= '0;
            if (acc.wr) begin
                case (acc.sel)
                    SEL_DATA: if (dlab) dll_q <= bus_wdata;
                              else      tx_q  <= bus_wdata[BYTE_W-1:0];
                    SEL_IER:  if (dlab) dlh_q <= bus_wdata;
                              else      ier_q <= bus_wdata;
                    SEL_LCR:  lcr_q  <= bus_wdata;
                    SEL_MCR:  mcr_q  <= bus_wdata;
                    SEL_SCR:  scr_q  <= bus_wdata;
                    SEL_GCTL: gctl_q <= bus_wdata;
                    default:  ;
                endcase
            end
            if (data_wr)       tx_valid_q <= 1'b1;
            else if (tx_ready) tx_valid_q <= 1'b0;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign tx_data   = tx_q;
    assign tx_valid  = tx_valid_q;
    assign tx_event  = tx_event_q;
    assign rx_event  = ier_q[IER_RX_BIT] && dr_live;

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid);
    assert_tx_event_cause_R6: assert property (@(posedge clk) disable iff (rst)
        tx_event |-> $past(bus_wr) && !bus_err);
    assert_err_no_send_R10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> !$rose(tx_valid));
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0, tx_idle = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready, tx_event, rx_event;

    int  checks = 0, failures = 0;
    bit  done = 1'b0, due = 1'b0;
    logic rx_ready_seen;

    typedef struct {
        logic [15:0] data;
        logic        err;
        bit          cmp_data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    uart_regfile #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idle(tx_idle),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_event(tx_event), .rx_event(rx_event)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) due <= !rst && (bus_rd || bus_wr);

    always @(negedge clk) begin
        if (due) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " err"}, bus_err, e.err);
                if (e.cmp_data) chk({e.tag, " data"}, bus_rdata, e.data);
            end
        end
    end

    task automatic acc(input bit is_rd, input logic [7:0] a, input logic [15:0] d,
                       input logic [1:0] sz, input logic [15:0] exp,
                       input logic exp_err, input string tag);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d;
        bus_rd = is_rd; bus_wr = !is_rd;
        sb_q.push_back('{exp, exp_err, is_rd, tag});
        #1 rx_ready_seen = rx_ready;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd16(input logic [7:0] a, input logic [15:0] exp, input string tag);
        acc(1'b1, a, 16'h0, 2'd1, exp, 1'b0, tag);
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d, input string tag);
        acc(1'b0, a, d, 2'd1, 16'h0, 1'b0, tag);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_valid reset", tx_valid, 0);
        chk("R1 rx_ready reset", rx_ready, 0);
        chk("R1 tx_event reset", tx_event, 0);
        chk("R1 rx_event reset", rx_event, 0);
        chk("R1 bus_err reset", bus_err, 0);
        rd16(8'h14, 16'h0060, "R1 R4 lsr reset");
        rd16(8'h14, 16'h0000, "R4 lsr cleared");
        rd16(8'h08, 16'h0001, "R1 ident");
        rd16(8'h04, 16'h0000, "R1 ier");
        rd16(8'h0C, 16'h0000, "R1 lcr");
        rd16(8'h10, 16'h0000, "R1 mcr");
        rd16(8'h1C, 16'h0000, "R1 scr");
        rd16(8'h24, 16'h0000, "R1 gctl");

        // R2 divisor aliasing
        wr16(8'h0C, 16'h0080, "R2 set div bit");
        rd16(8'h00, 16'h0001, "R1 R2 divisor low reset");
        rd16(8'h04, 16'h0000, "R1 R2 divisor high reset");
        wr16(8'h00, 16'h1234, "R2 div low wr");
        chk("R2 no send under div", tx_valid, 0);
        wr16(8'h04, 16'h00AB, "R2 div high wr");
        rd16(8'h00, 16'h1234, "R2 div low rd");
        rd16(8'h04, 16'h00AB, "R2 div high rd");
        wr16(8'h0C, 16'h0000, "R2 clr div bit");
        rd16(8'h04, 16'h0000, "R2 ier unaliased");

        // R3 storage and ignored writes
        wr16(8'h08, 16'hFFFF, "R3 ident wr");
        wr16(8'h14, 16'hFFFF, "R3 lsr wr");
        rd16(8'h08, 16'h0001, "R3 ident unchanged");
        rd16(8'h14, 16'h0000, "R3 lsr unchanged");
        wr16(8'h1C, 16'hBEEF, "R3 scr wr");
        wr16(8'h24, 16'h8001, "R3 gctl wr");
        wr16(8'h10, 16'h0003, "R3 mcr wr");
        wr16(8'h0C, 16'h7F03, "R3 lcr wr");
        rd16(8'h1C, 16'hBEEF, "R3 scr rd");
        rd16(8'h24, 16'h8001, "R3 gctl rd");
        rd16(8'h10, 16'h0003, "R3 mcr rd");
        rd16(8'h0C, 16'h7F03, "R3 lcr rd");
        wr16(8'h10, 16'h0000, "R3 mcr clr");
        wr16(8'h0C, 16'h0000, "R3 lcr clr");

        // R4 live merge
        tx_ready = 1'b1; tx_idle = 1'b1;
        rd16(8'h14, 16'h0060, "R4 live empty");
        tx_idle = 1'b0;
        rd16(8'h14, 16'h0020, "R4 live thre only");
        tx_ready = 1'b0;

        // R5 R6 transmit
        wr16(8'h04, 16'h0002, "R6 ier tx");
        wr16(8'h00, 16'h01A5, "R5 data wr");
        chk("R5 tx_valid", tx_valid, 1);
        chk("R5 tx_data", tx_data, 8'hA5);
        chk("R6 tx_event pulse", tx_event, 1);
        @(negedge clk);
        chk("R6 tx_event one cycle", tx_event, 0);
        chk("R5 tx_valid held", tx_valid, 1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R5 tx accepted", tx_valid, 0);
        wr16(8'h04, 16'h0000, "R6 ier off");
        wr16(8'h00, 16'h0011, "R6 data wr no event");
        chk("R6 no tx_event", tx_event, 0);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;

        // R7 R9 external receive
        wr16(8'h04, 16'h0001, "R9 ier rx");
        rx_data = 8'h3C; rx_valid = 1'b1;
        #1 chk("R9 rx_event with data", rx_event, 1);
        rd16(8'h14, 16'h0001, "R4 dr live");
        rd16(8'h00, 16'h003C, "R7 rx pop");
        chk("R7 rx_ready in strobe", rx_ready_seen, 1);
        rx_valid = 1'b0;
        #1 chk("R9 rx_event no data", rx_event, 0);
        rd16(8'h00, 16'h003C, "R7 previous byte");
        chk("R7 no pop when empty", rx_ready_seen, 0);
        rd16(8'h14, 16'h0000, "R4 dr clear");

        // R8 loopback
        wr16(8'h10, 16'h0010, "R8 loop on");
        rx_data = 8'h77; rx_valid = 1'b1;
        #1 chk("R8 R9 external ignored", rx_event, 0);
        wr16(8'h00, 16'h005A, "R8 loop wr");
        chk("R8 still sent", tx_data, 8'h5A);
        chk("R8 rx_event loop byte", rx_event, 1);
        rd16(8'h00, 16'h005A, "R8 loop rd");
        chk("R8 rx_ready low", rx_ready_seen, 0);
        rd16(8'h00, 16'h005A, "R8 loop drained");
        chk("R8 rx_ready low again", rx_ready_seen, 0);
        rx_valid = 1'b0;
        wr16(8'h10, 16'h0000, "R8 loop off");
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;

        // R10 invalid accesses
        acc(1'b1, 8'h18, 16'h0, 2'd1, 16'h0, 1'b1, "R10 msr rd");
        acc(1'b0, 8'h20, 16'h5555, 2'd1, 16'h0, 1'b1, "R10 reserved wr");
        acc(1'b1, 8'h28, 16'h0, 2'd1, 16'h0, 1'b1, "R10 past map rd");
        acc(1'b1, 8'h1E, 16'h0, 2'd1, 16'h0, 1'b1, "R10 misaligned rd");
        acc(1'b0, 8'h1C, 16'h1111, 2'd0, 16'h0, 1'b1, "R10 byte wr");
        acc(1'b0, 8'h00, 16'h0099, 2'd2, 16'h0, 1'b1, "R10 word data wr");
        chk("R10 no send on bad", tx_valid, 0);
        acc(1'b0, 8'h0D, 16'h0080, 2'd1, 16'h0, 1'b1, "R10 misaligned lcr wr");
        @(negedge clk);
        bus_addr = 8'h1C; bus_size = 2'd1; bus_rd = 1'b1; bus_wr = 1'b1;
        sb_q.push_back('{16'h0, 1'b1, 1'b1, "R10 both strobes"});
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        rd16(8'h1C, 16'hBEEF, "R10 scr unchanged");
        rd16(8'h04, 16'h0001, "R10 ier not aliased");

        // R11 hold
        repeat (3) @(negedge clk);
        chk("R11 rdata held", bus_rdata, 16'h0001);

        repeat (2) @(negedge clk);
        done = 1'b1;
        report();
    end
endmodule